// File: doc/BRIEF.md
# Keyed Flash Mode-Entry Register

This block is a 16-bit control register on a simple register bus. It moves three flash regions between read mode and program/erase mode. The regions are one data region and two code regions. A write takes effect only when the same word carries a key code in its upper byte. Any other write to the register clears every mode bit. The key byte is never stored.

If a keyed write selects more than one region, the block sets a sticky illegal-operation flag and a command-lock flag. Both stay set until system reset or a soft flash reset. A command-ready output tells the command sequencer when exactly one region is in program/erase mode and no lock is pending. While the flash-disable input is high, the register reads as zero and ignores every write.

Top module: `flash_mode_gate`

## Requirements
- R1: A write to the register address with both byte enables set (`byte_en` = 2'b11) and `wdata[15:8]` equal to the key (default 8'hAA) loads `wdata[7]` into the data-region bit and `wdata[1:0]` into the two code-region bits at the next rising clock edge.
- R2: A read of the register address returns the data-region bit on `rdata[7]` and the code-region bits on `rdata[1:0]`. `rdata[6:2]` and `rdata[15:8]` always read 0, whatever was written to them.
- R3: A full-word write to the register address whose upper byte is not the key clears all three mode bits at the next edge.
- R4: A write to the register address with `byte_en` other than 2'b11 clears all three mode bits at the next edge, even if it carries the key.
- R5: A keyed write that sets two or more mode bits raises `illegal_err` and `cmd_lock` at the next edge.
- R6: Once raised, `illegal_err` and `cmd_lock` stay high through any later writes, keyed or not, until reset or `soft_clr`.
- R7: `cmd_ready` is high exactly when one mode bit is set and `cmd_lock` is low.
- R8: While `flash_off` is high, `rdata` is 0000h and writes change no state, including writes that would otherwise clear the register.
- R9: `soft_clr` clears the mode bits, `illegal_err` and `cmd_lock` at the next edge. It takes priority over a write in the same cycle.
- R10: Asserting `rst_n` low clears all state at once. After `rst_n` is released, writes take effect only from the third rising edge onward.
- R11: Writes to any other address change nothing, and reads of any other address return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| soft_clr | input | 1 | Synchronous soft flash reset |
| flash_off | input | 1 | Flash disabled: reads return zero, writes are blocked |
| addr | input | 4 | Register bus address |
| wr_en | input | 1 | Write strobe |
| byte_en | input | 2 | Byte enables; bit 1 is the upper byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| data_pe | output | 1 | Data region is in program/erase mode |
| code_pe | output | 2 | Code regions are in program/erase mode |
| illegal_err | output | 1 | Sticky flag: more than one region was selected |
| cmd_lock | output | 1 | Command sequencer is locked |
| cmd_ready | output | 1 | Sequencer may accept program/erase commands |

## Verification
The assertions assume that `soft_clr`, `flash_off` and the bus inputs are synchronous to `clk` and steady around its rising edge. They also assume that `rst_n` is the only asynchronous input. The bench keeps within these limits by changing every input on the falling edge. It holds `rst_n` low across several edges and lets the synchronizer release before it issues any write. The random phase weights the key value, the byte enables and the address so that keyed loads, clears, multi-bit errors and blocked writes all occur often. The bench checks every output against its reference model on every cycle.

// File: rtl/fme_pkg.sv
package fme_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned DATA_BIT = 7;

  typedef struct packed {
    logic       data;
    logic [1:0] code;
  } mode_t;

  function automatic logic [1:0] mode_count(input mode_t m);
    mode_count = 2'(m.data) + 2'(m.code[1]) + 2'(m.code[0]);
  endfunction
endpackage

// File: rtl/fme_rst_sync.sv
module fme_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/fme_key_check.sv
module fme_key_check #(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter logic [7:0] KEY = 8'hAA
) (
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [fme_pkg::BE_W-1:0] byte_en,
  input  logic [7:0]              key_byte,
  input  logic                    flash_off,
  output logic                    hit,
  output logic                    keyed
);
  always_comb begin
    hit   = wr_en && (addr == REG_ADDR) && !flash_off;
    keyed = (byte_en == '1) && (key_byte == KEY);
  end
endmodule

// File: rtl/fme_err_track.sv
module fme_err_track
  import fme_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr,
  input  logic  load,
  input  mode_t wbits,
  output logic  err_q
);
  logic err_d;
  logic multi;

  always_comb begin
    multi = mode_count(wbits) > 2'd1;
    err_d = err_q;
    if (soft_clr)           err_d = 1'b0;
    else if (load && multi) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !soft_clr) |=> err_q);
  // R9
  err_soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !err_q);
endmodule

// File: rtl/fme_mode_reg.sv
module fme_mode_reg
  import fme_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  soft_clr,
  input  logic  hit,
  input  logic  keyed,
  input  mode_t wbits,
  output mode_t mode_q
);
  mode_t mode_d;
  logic  mode_en;

  always_comb begin
    mode_en = soft_clr || hit;
    mode_d  = mode_q;
    if (soft_clr)   mode_d = '0;
    else if (keyed) mode_d = wbits;
    else            mode_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  // R3 R4
  bad_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !keyed) |=> (mode_q == '0));
  // R1
  keyed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && keyed && !soft_clr) |=> (mode_q == $past(wbits)));
  // R9
  mode_soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (mode_q == '0));
endmodule

// File: rtl/flash_mode_gate.sv
module flash_mode_gate
  import fme_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h2,
  parameter logic [7:0] KEY = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              flash_off,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BE_W-1:0]   byte_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              data_pe,
  output logic [1:0]        code_pe,
  output logic              illegal_err,
  output logic              cmd_lock,
  output logic              cmd_ready
);
  logic  rst_n_s;
  logic  hit;
  logic  keyed;
  logic  err_q;
  mode_t wbits;
  mode_t mode_q;

  fme_rst_sync i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  fme_key_check #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .KEY      (KEY)
  ) i_key_check (
    .wr_en     (wr_en),
    .addr      (addr),
    .byte_en   (byte_en),
    .key_byte  (wdata[DATA_W-1:HALF_W]),
    .flash_off (flash_off),
    .hit       (hit),
    .keyed     (keyed)
  );

  always_comb begin
    wbits.data = wdata[DATA_BIT];
    wbits.code = wdata[1:0];
  end

  fme_mode_reg i_mode_reg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .soft_clr (soft_clr),
    .hit      (hit),
    .keyed    (keyed),
    .wbits    (wbits),
    .mode_q   (mode_q)
  );

  fme_err_track i_err_track (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .soft_clr (soft_clr),
    .load     (hit && keyed),
    .wbits    (wbits),
    .err_q    (err_q)
  );

  always_comb begin
    rdata = '0;
    if (!flash_off && (addr == REG_ADDR)) begin
      rdata[DATA_BIT] = mode_q.data;
      rdata[1:0]      = mode_q.code;
    end
  end

  assign data_pe     = mode_q.data;
  assign code_pe     = mode_q.code;
  assign illegal_err = err_q;
  assign cmd_lock    = err_q;
  assign cmd_ready   = (mode_count(mode_q) == 2'd1) && !err_q;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rdata[DATA_W-1:HALF_W] == '0) && (rdata[6:2] == '0));
  // R7
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_ready |-> (($countones({data_pe, code_pe}) == 1) && !cmd_lock));
  // R8
  off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flash_off && !soft_clr) |=> ($stable(data_pe) && $stable(code_pe) && $stable(illegal_err)));
  // R8
  off_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    flash_off |-> (rdata == '0));
  // R5
  multi_sets_lock_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (hit && keyed && !soft_clr && ($countones(wbits) > 1)) |=> (cmd_lock && illegal_err));
endmodule

// File: tb/test_flash_mode_gate.sv
module test_flash_mode_gate;
  localparam logic [3:0] RA  = 4'h2;
  localparam logic [7:0] KY  = 8'hAA;

  logic        clk = 1'b0;
  logic        rst_n, soft_clr, flash_off, wr_en;
  logic [3:0]  addr;
  logic [1:0]  byte_en;
  logic [15:0] wdata, rdata;
  logic        data_pe, illegal_err, cmd_lock, cmd_ready;
  logic [1:0]  code_pe;

  int vectors = 0;
  int fails   = 0;
  int m_mode  = 0;   // model: bit2 data, bits1:0 code
  bit m_err   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  flash_mode_gate i_flash_mode_gate (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .flash_off(flash_off),
    .addr(addr), .wr_en(wr_en), .byte_en(byte_en), .wdata(wdata),
    .rdata(rdata), .data_pe(data_pe), .code_pe(code_pe),
    .illegal_err(illegal_err), .cmd_lock(cmd_lock), .cmd_ready(cmd_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bitcnt(input int v);
    int n = 0;
    for (int i = 0; i < 3; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic compare(input string tag);
    int exp_rd;
    exp_rd = 0;
    if (!flash_off && addr == RA) exp_rd = ((m_mode >> 2) & 1) * 128 + (m_mode & 3);
    chk({tag, " R2 R8 R11 rdata"}, int'(rdata), exp_rd);
    chk({tag, " R1 R3 R4 mode"}, int'({data_pe, code_pe}), m_mode);
    chk({tag, " R5 R6 err"}, int'(illegal_err), int'(m_err));
    chk({tag, " R5 R6 lock"}, int'(cmd_lock), int'(m_err));
    chk({tag, " R7 ready"}, int'(cmd_ready), int'(bitcnt(m_mode) == 1 && !m_err));
  endtask

  // Apply inputs just after a falling edge, compare, then advance one edge.
  task automatic cyc(input string tag, input bit sc, input bit off, input bit we,
                     input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    soft_clr = sc; flash_off = off; wr_en = we; addr = a; byte_en = be; wdata = d;
    #1 compare(tag);
    @(posedge clk);
    if (sc) begin
      m_mode = 0; m_err = 0;
    end else if (we && !off && a == RA) begin
      if (be == 2'b11 && d[15:8] == KY) begin
        m_mode = {29'd0, d[7], d[1:0]};
        if (bitcnt(m_mode) > 1) m_err = 1;
      end else m_mode = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, 0, RA, 2'b00, 16'h0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_clr = 0; flash_off = 0; wr_en = 0; addr = RA; byte_en = 0; wdata = 0;
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    idle("R10 after release");
    // R1 single-bit keyed loads
    cyc("R1 data", 0, 0, 1, RA, 2'b11, {KY, 8'h80});
    cyc("R1 code0", 0, 0, 1, RA, 2'b11, {KY, 8'h01});
    cyc("R1 code1", 0, 0, 1, RA, 2'b11, {KY, 8'h7E});
    idle("R2 reserved ignored");
    // R3 bad key
    cyc("R3 badkey", 0, 0, 1, RA, 2'b11, {8'h55, 8'h80});
    idle("R3 cleared");
    cyc("R1 reload", 0, 0, 1, RA, 2'b11, {KY, 8'h80});
    // R4 byte writes with key
    cyc("R4 lo byte", 0, 0, 1, RA, 2'b01, {KY, 8'h80});
    cyc("R1 reload2", 0, 0, 1, RA, 2'b11, {KY, 8'h02});
    cyc("R4 hi byte", 0, 0, 1, RA, 2'b10, {KY, 8'h02});
    idle("R4 cleared");
    // R11 other address
    cyc("R1 reload3", 0, 0, 1, RA, 2'b11, {KY, 8'h01});
    cyc("R11 other", 0, 0, 1, 4'h3, 2'b11, {8'h00, 8'h00});
    cyc("R11 read other", 0, 0, 0, 4'h3, 2'b00, 16'h0);
    // R8 flash_off
    cyc("R8 off write", 0, 1, 1, RA, 2'b11, {8'h00, 8'h00});
    cyc("R8 off read", 0, 1, 0, RA, 2'b00, 16'h0);
    idle("R8 kept");
    // R5 multi-bit
    cyc("R5 multi", 0, 0, 1, RA, 2'b11, {KY, 8'h81});
    idle("R5 locked");
    // R6 sticky
    cyc("R6 single after", 0, 0, 1, RA, 2'b11, {KY, 8'h01});
    cyc("R6 badkey after", 0, 0, 1, RA, 2'b11, 16'h0001);
    idle("R6 still locked");
    // R9 soft clear wins over write
    cyc("R9 soft+write", 1, 0, 1, RA, 2'b11, {KY, 8'h80});
    idle("R9 cleared");
    // R10 async reset mid-run
    cyc("R1 pre-reset", 0, 0, 1, RA, 2'b11, {KY, 8'h83});
    #3 rst_n = 0; m_mode = 0; m_err = 0;
    #2 compare("R10 async clear");
    @(negedge clk); rst_n = 1;
    cyc("R10 blocked1", 0, 0, 1, RA, 2'b11, {KY, 8'h80});
    m_mode = 0;
    compare("R10 write ignored");
    repeat (3) idle("R10 settle");
    // Random phase
    for (int n = 0; n < 2000; n++) begin
      bit sc, off, we;
      logic [3:0] a;
      logic [1:0] be;
      logic [15:0] d;
      sc  = ($urandom_range(0, 31) == 0);
      off = ($urandom_range(0, 9) == 0);
      we  = ($urandom_range(0, 3) != 0);
      a   = ($urandom_range(0, 7) == 0) ? 4'($urandom) : RA;
      be  = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b11;
      d   = 16'($urandom);
      if ($urandom_range(0, 3) != 0) d[15:8] = KY;
      cyc("rand", sc, off, we, a, be, d);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule